// File: doc/BRIEF.md
# Width-Adaptive LFSR Pseudo-Random Counter

This block steps through a pseudo-random sequence of states using a shift register with XNOR feedback. The register width is set by a parameter, from 2 to 32 bits. The feedback taps are chosen when the design is elaborated. They come from a built-in table of maximal-length polynomials, so every width cycles through all states except one, and the sequence length is 2^WIDTH - 1.

The width decides how many register bits feed the XNOR:
- **Two-term class:** widths 2-7, 9-11, 15, 17, 18, 20-23, 25, 28, 29 and 31. The feedback is a single gate level.
- **Wider class:** widths 8, 12-14, 16, 19, 24, 26, 27, 30 and 32. The feedback is a tree of gates.

Because the feedback uses XNOR, the all-zeros state is a normal member of the sequence and is where the asynchronous clear puts the register. The all-ones state is the one state from which the register could never leave, so the design must never enter it.

The host steps the sequence with a count enable. It can also place a seed with a synchronous load. If a seed equals the all-ones state, the block stores zero instead.

Top module: `lfsr_prng_counter`

## Requirements
- R1: While the active-low clear `clr_n` is 0, `state` is all zeros, at once and without waiting for a clock edge. This holds even when the counter was in the middle of a sequence.
- R2: On a rising clock edge with `seed_ld` = 0 and `adv` = 0, `state` keeps its value.
- R3: On a rising clock edge with `seed_ld` = 0 and `adv` = 1, the register shifts toward its most significant bit. The new bit 0 is the XNOR of the tap bits. For WIDTH = 4 the taps are bits 3 and 2, so the next state is {state[2:0], ~(state[3]^state[2])}.
- R4: On a rising clock edge with `seed_ld` = 1, `state` takes the value of `seed` whatever the level of `adv`, provided `seed` is not all ones.
- R5: A load whose `seed` is all ones stores all zeros instead.
- R6: Outside of loads and clear, `state` never takes the all-ones value.
- R7: For the two-term widths (3, 5, 6, 7, 9, 10 and 11 among them), starting from zero with `adv` held at 1, `state` first returns to zero after exactly 2^WIDTH - 1 edges.
- R8: For the wider widths (8, 12, 13, 14 and 16 among them), starting from zero with `adv` held at 1, `state` first returns to zero after exactly 2^WIDTH - 1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear to zero, active low |
| adv | input | 1 | Count enable; the sequence moves one step per edge while high |
| seed_ld | input | 1 | Synchronous seed load; takes priority over `adv` |
| seed | input | WIDTH | Seed value for loads |
| state | output | WIDTH | Current register contents |

## Verification
A 4-bit instance is driven through several kinds of stimulus:
- **Uninterrupted stepping** that wraps the whole 15-state cycle. This separates a correct shift direction and tap pair from a wrong one.
- **Held-enable gaps.** These show the state holds instead of drifting.
- **Loads with `adv` both low and high.** These show that loading wins over counting, including a seed of all ones, which must turn into zero.
- **A clear in the middle of a sequence.** This shows the clear is asynchronous.

Free-running instances at twelve widths, covering both tap classes, measure the cycle length against 2^WIDTH - 1. Any wrong tap entry would shorten that cycle, or trap the register in all ones.

// File: rtl/lfsr_prng_counter.sv
module lfsr_prng_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             adv,
  input  logic             seed_ld,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state
);

  // Bit index of tap k for width w; -1 marks an unused slot.
  function automatic int tap_bit(input int w, input int k);
    int t [4];
    t = '{-1, -1, -1, -1};
    case (w)
      2:  t = '{1, 0, -1, -1};
      3:  t = '{2, 1, -1, -1};
      4:  t = '{3, 2, -1, -1};
      5:  t = '{4, 2, -1, -1};
      6:  t = '{5, 4, -1, -1};
      7:  t = '{6, 5, -1, -1};
      8:  t = '{7, 5, 4, 3};
      9:  t = '{8, 4, -1, -1};
      10: t = '{9, 6, -1, -1};
      11: t = '{10, 8, -1, -1};
      12: t = '{11, 5, 3, 0};
      13: t = '{12, 3, 2, 0};
      14: t = '{13, 4, 2, 0};
      15: t = '{14, 13, -1, -1};
      16: t = '{15, 14, 12, 3};
      17: t = '{16, 13, -1, -1};
      18: t = '{17, 10, -1, -1};
      19: t = '{18, 5, 1, 0};
      20: t = '{19, 16, -1, -1};
      21: t = '{20, 18, -1, -1};
      22: t = '{21, 20, -1, -1};
      23: t = '{22, 17, -1, -1};
      24: t = '{23, 22, 21, 16};
      25: t = '{24, 21, -1, -1};
      26: t = '{25, 5, 1, 0};
      27: t = '{26, 4, 1, 0};
      28: t = '{27, 24, -1, -1};
      29: t = '{28, 26, -1, -1};
      30: t = '{29, 5, 3, 0};
      31: t = '{30, 27, -1, -1};
      32: t = '{31, 21, 1, 0};
      default: t = '{1, 0, -1, -1};
    endcase
    return t[k];
  endfunction

  localparam int T0       = tap_bit(WIDTH, 0);
  localparam int T1       = tap_bit(WIDTH, 1);
  localparam bit TWO_TERM = (tap_bit(WIDTH, 2) < 0);
  localparam logic [WIDTH-1:0] LOCKUP = '1;

  logic fb;

  generate
    if (TWO_TERM) begin : g_two
      assign fb = ~(state[T0] ^ state[T1]);
    end else begin : g_four
      localparam int T2 = tap_bit(WIDTH, 2);
      localparam int T3 = tap_bit(WIDTH, 3);
      logic pair_hi, pair_lo;
      assign pair_hi = state[T0] ^ state[T1];
      assign pair_lo = state[T2] ^ state[T3];
      assign fb      = ~(pair_hi ^ pair_lo);
    end
  endgenerate

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      state <= '0;
    else if (seed_ld)
      state <= (seed == LOCKUP) ? '0 : seed;
    else if (adv)
      state <= {state[WIDTH-2:0], fb};
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) !clr_n |-> state == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!seed_ld && !adv) |=> $stable(state));

  // R3
  shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!seed_ld && adv) |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (seed_ld && seed != LOCKUP) |=> state == $past(seed));

  // R5
  lock_seed_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (seed_ld && seed == LOCKUP) |=> state == '0);

  // R6
  no_lockup_chk: assert property (@(posedge clk) disable iff (!clr_n)
    state != LOCKUP);

endmodule

// File: tb/tb_lfsr_prng_counter.sv
`timescale 1ns/1ps
module tb_lfsr_prng_counter;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       pclr_n = 1'b0;
  logic       adv = 1'b0;
  logic       seed_ld = 1'b0;
  logic [3:0] seed = 4'h0;
  logic [3:0] state;

  int  nchk = 0;
  int  nerr = 0;
  bit  ended = 1'b0;

  always #2.5 clk = ~clk;

  lfsr_prng_counter #(.WIDTH(4)) dut (
    .clk(clk), .clr_n(clr_n), .adv(adv), .seed_ld(seed_ld),
    .seed(seed), .state(state)
  );

  // Period measurement across both tap classes; first 7 are two-term.
  localparam int NP = 12;
  localparam int WL [NP] = '{3, 5, 6, 7, 9, 10, 11, 8, 12, 13, 14, 16};
  logic [NP-1:0] pdone;

  generate
    for (genvar i = 0; i < NP; i++) begin : g_per
      localparam int W = WL[i];
      logic [W-1:0] q;
      bit done = 1'b0;
      bit seen_ones = 1'b0;
      int cyc = 0;
      assign pdone[i] = done;
      lfsr_prng_counter #(.WIDTH(W)) u (
        .clk(clk), .clr_n(pclr_n), .adv(1'b1), .seed_ld(1'b0),
        .seed({W{1'b0}}), .state(q)
      );
      always @(negedge clk) begin
        if (pclr_n && !done) begin
          cyc++;
          if (q == {W{1'b1}}) seen_ones = 1'b1;
          if (q == '0) begin
            nchk++;
            if (cyc != (1 << W) - 1 || seen_ones) begin
              nerr++;
              $display("FAIL %s width %0d: period %0d lockup_seen %0d, expected %0d lockup_seen 0",
                       (i < 7) ? "R7" : "R8", W, cyc, seen_ones, (1 << W) - 1);
            end
            done = 1'b1;
          end
        end
      end
    end
  endgenerate

  // Scoreboard for the 4-bit instance
  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t      sb [$];
  logic [3:0] model = 4'h0;

  function automatic logic [3:0] nxt4(input logic [3:0] s);
    return {s[2:0], ~(s[3] ^ s[2])};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: state %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit a, input bit l, input logic [3:0] s, input string tag);
    item_t it;
    @(negedge clk);
    adv = a; seed_ld = l; seed = s;
    if (l) model = (s == 4'hF) ? 4'h0 : s;
    else if (a) model = nxt4(model);
    it.exp = model;
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, state, it.exp);
      // R6
      nchk++;
      if (state === 4'hF) begin
        nerr++;
        $display("FAIL R6: state %h, expected not f", state);
      end
    end
  end

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run incomplete, expected all done");
    finish_run();
  end

  initial begin
    #1;
    check("R1 reset", state, 4'h0);
    @(negedge clk); #1;
    clr_n = 1'b1;
    pclr_n = 1'b1;
    // R3: full cycle plus wrap
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 4'h0, "R3");
    // R2: holds
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 4'h6, "R2");
    // R4: load with adv low, then with adv high
    step(1'b0, 1'b1, 4'h9, "R4");
    step(1'b0, 1'b0, 4'h0, "R2");
    step(1'b1, 1'b1, 4'h5, "R4");
    step(1'b1, 1'b0, 4'h0, "R3");
    // R5: lock-up seed becomes zero
    step(1'b1, 1'b1, 4'hF, "R5");
    step(1'b1, 1'b0, 4'h0, "R3");
    step(1'b1, 1'b0, 4'h0, "R3");
    step(1'b0, 1'b1, 4'hF, "R5");
    for (int k = 0; k < 6; k++) step(k[0], 1'b0, 4'h0, k[0] ? "R3" : "R2");
    step(1'b0, 1'b1, 4'hE, "R4");
    step(1'b1, 1'b0, 4'h0, "R3");
    @(posedge clk); #2;
    // R1: asynchronous clear mid-sequence
    check("R1 pre", state, model);
    #0.5 clr_n = 1'b0;
    #0.5 check("R1 clear", state, 4'h0);
    model = 4'h0;
    adv = 1'b0; seed_ld = 1'b0;
    @(negedge clk); #1;
    clr_n = 1'b1;
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 4'h0, "R3");
    @(posedge clk); #2;
    wait (&pdone);
    @(negedge clk);
    finish_run();
  end

endmodule